// File: doc/BRIEF.md
# Backend Stage Flow Controller

This block governs the flow of instruction bundles through one out-of-order backend stage. The stage sits between a rename stage upstream and a commit stage downstream. In normal operation a bundle passes straight through in the cycle it arrives. The block tracks the stage mode and tells upstream when to hold.

When the downstream stage asks for a hold, or the issue queue is full, the block parks arriving bundles in a small skid FIFO. Once the hold conditions clear, it replays the parked bundles one per cycle in arrival order. Upstream stays held until the FIFO has drained.

A flush request from commit, or a reorder-buffer rollback, sends the stage into a flushing mode. That mode discards all parked work. It ends with a one-cycle acknowledge pulse toward the issue queue.

Top module: `stage_flow_ctrl`

## Requirements
- R1: After reset, `status` is Idle (encoding 0), and both `stallUp` and `outValid` are low. The status encodings are Idle=0, Running=1, Blocked=2, Squashing=3 and Unblocking=4.
- R2: In Idle or Running with no hold, flush or full-queue condition, `outValid` equals `inValid` and `outData` equals `inData` in the same cycle. A passed bundle moves the status to Running on the next edge.
- R3: In Idle or Running, `commitStall` moves the status to Blocked on the next edge and parks the bundle offered that cycle. Nothing is output in that cycle.
- R4: In Idle or Running, a valid bundle offered while `queueFull` is high is not output. It is parked, and the status becomes Blocked.
- R5: While Blocked, `stallUp` is high in every cycle, and each valid bundle offered is parked behind the earlier ones.
- R6: Blocked moves to Unblocking only in a cycle where `commitStall` and `queueFull` are both low. Otherwise it stays Blocked.
- R7: In Unblocking, exactly one parked bundle is output per cycle, oldest first. `stallUp` stays high while parked bundles remain, and the status returns to Running after the last one.
- R8: A flush request (`commitSquash` or `robSquash`) while Blocked moves the status to Squashing and discards every parked bundle, so none is replayed later.
- R9: Squashing persists while either `commitSquash` or `robSquash` is high. In the first cycle both are low, `stopSquash` pulses high for one cycle and the status returns to Running. No bundle is output while Squashing.
- R10: In Idle or Running, `commitStall` takes priority over a simultaneous flush request. Without a stall, a flush request moves the status to Squashing.
- R11: The skid FIFO holds up to SKID_DEPTH bundles (default 4). A full FIFO replays all of them in order, and it is never pushed when full nor popped when empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Upstream bundle present |
| inData | input | DATA_W | Upstream bundle payload |
| commitStall | input | 1 | Hold request from commit |
| commitSquash | input | 1 | Flush request from commit |
| robSquash | input | 1 | Reorder buffer rollback in progress |
| queueFull | input | 1 | Issue queue has no free entry |
| stallUp | output | 1 | Hold request to upstream |
| outValid | output | 1 | Bundle selected for processing this cycle |
| outData | output | DATA_W | Selected bundle payload |
| status | output | 3 | Current stage mode |
| stopSquash | output | 1 | One-cycle end-of-flush pulse to issue queue |

## Verification
The bench sweeps the number of parked bundles from one to a full FIFO and checks that each is replayed in order. A wrong read pointer would reorder the replay, and a wrong exit condition would drop the last bundle or emit a stale one. It holds a hold or a full queue while Blocked to show that the exit waits for both to clear.

It checks that a rollback flag alone keeps the stage flushing, and that a stall beats a simultaneous flush. A controller that ignored the rollback flag would release the flush early. It also re-enters Blocked after a flush with nothing parked. A FIFO that was not cleared on the flush would then replay stale work.

// File: rtl/stage_flow_pkg.sv
package stage_flow_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RUNNING  = 3'd1,
    ST_BLOCKED  = 3'd2,
    ST_SQUASH   = 3'd3,
    ST_UNBLOCK  = 3'd4
  } stage_state_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } skid_cmd_t;
endpackage

// File: rtl/stage_skid_fifo.sv
module stage_skid_fifo
  import stage_flow_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  skid_cmd_t         cmd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] headData,
  output logic              isEmpty,
  output logic              isFull,
  output logic              hasOne
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || cmd.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (cmd.push) wrPtr <= bump(wrPtr);
      if (cmd.pop)  rdPtr <= bump(rdPtr);
      case ({cmd.push, cmd.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cmd.push && !cmd.flush) mem[wrPtr] <= wrData;
  end

  assign headData = mem[rdPtr];
  assign isEmpty  = (count == '0);
  assign isFull   = (count == CW'(DEPTH));
  assign hasOne   = (count == CW'(1));

  // R11: occupancy never exceeds DEPTH one cycle after a push
  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (count <= CW'(DEPTH)));
endmodule

// File: rtl/stage_flow_fsm.sv
module stage_flow_fsm
  import stage_flow_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         commitStall,
  input  logic         commitSquash,
  input  logic         robSquash,
  input  logic         queueFull,
  input  logic         skidEmpty,
  input  logic         skidFull,
  input  logic         skidOne,
  output skid_cmd_t    cmd,
  output stage_state_t state,
  output logic         stallUp,
  output logic         outValid,
  output logic         selSkid,
  output logic         stopSquash
);
  stage_state_t nxt;
  logic flushReq;

  assign flushReq = commitSquash | robSquash;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt        = state;
    cmd        = '0;
    stallUp    = 1'b0;
    outValid   = 1'b0;
    selSkid    = 1'b0;
    stopSquash = 1'b0;
    unique case (state)
      ST_IDLE, ST_RUNNING: begin
        if (commitStall) begin
          nxt      = ST_BLOCKED;
          cmd.push = inValid;
        end else if (flushReq) begin
          nxt       = ST_SQUASH;
          cmd.flush = 1'b1;
        end else if (inValid && queueFull) begin
          nxt      = ST_BLOCKED;
          cmd.push = 1'b1;
        end else begin
          outValid = inValid;
          if (inValid) nxt = ST_RUNNING;
        end
      end
      ST_BLOCKED: begin
        stallUp = 1'b1;
        if (flushReq) begin
          nxt       = ST_SQUASH;
          cmd.flush = 1'b1;
        end else begin
          cmd.push = inValid;
          if (!commitStall && !queueFull) nxt = ST_UNBLOCK;
        end
      end
      ST_UNBLOCK: begin
        stallUp = !skidEmpty;
        if (commitStall || (queueFull && !flushReq)) begin
          nxt      = ST_BLOCKED;
          cmd.push = inValid;
        end else if (flushReq) begin
          nxt       = ST_SQUASH;
          cmd.flush = 1'b1;
        end else begin
          cmd.push = inValid;
          if (!skidEmpty) begin
            cmd.pop  = 1'b1;
            outValid = 1'b1;
            selSkid  = 1'b1;
          end
          if ((skidEmpty || skidOne) && !inValid) nxt = ST_RUNNING;
        end
      end
      ST_SQUASH: begin
        if (!flushReq) begin
          nxt        = ST_RUNNING;
          stopSquash = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.push && !cmd.pop) |-> !skidFull);
  p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmd.pop |-> !skidEmpty);
  p_blocked_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BLOCKED) |-> stallUp);
  p_hold_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BLOCKED && !flushReq && (commitStall || queueFull)) |=> (state == ST_BLOCKED));
  p_squash_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SQUASH && flushReq) |=> (state == ST_SQUASH));
  p_stop_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopSquash |=> !stopSquash);
endmodule

// File: rtl/stage_flow_ctrl.sv
module stage_flow_ctrl
  import stage_flow_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SKID_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              commitStall,
  input  logic              commitSquash,
  input  logic              robSquash,
  input  logic              queueFull,
  output logic              stallUp,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [2:0]        status,
  output logic              stopSquash
);
  skid_cmd_t         cmd;
  stage_state_t      state;
  logic              skidEmpty, skidFull, skidOne, selSkid;
  logic [DATA_W-1:0] headData;

  stage_flow_fsm u_fsm (
    .clk(clk), .rstN(rstN), .inValid(inValid), .commitStall(commitStall),
    .commitSquash(commitSquash), .robSquash(robSquash), .queueFull(queueFull),
    .skidEmpty(skidEmpty), .skidFull(skidFull), .skidOne(skidOne),
    .cmd(cmd), .state(state), .stallUp(stallUp), .outValid(outValid),
    .selSkid(selSkid), .stopSquash(stopSquash)
  );

  stage_skid_fifo #(.DATA_W(DATA_W), .DEPTH(SKID_DEPTH)) u_skid (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(inData),
    .headData(headData), .isEmpty(skidEmpty), .isFull(skidFull), .hasOne(skidOne)
  );

  assign outData = selSkid ? headData : inData;
  assign status  = state;

  // R3: a stall seen in an active state yields Blocked next cycle
  p_stall_enters_block_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((status == 3'd0 || status == 3'd1) && commitStall) |=> (status == 3'd2));
  // R9: nothing is output while flushing
  p_quiet_squash_r9: assert property (@(posedge clk) disable iff (!rstN)
    (status == 3'd3) |-> !outValid);
endmodule

// File: tb/sim_stage_flow_ctrl.sv
module sim_stage_flow_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, commitStall = 1'b0, commitSquash = 1'b0, robSquash = 1'b0, queueFull = 1'b0;
  logic [15:0] inData = '0;
  logic stallUp, outValid, stopSquash;
  logic [15:0] outData;
  logic [2:0] status;

  int nRun = 0, nFail = 0;
  bit done = 0;
  logic sValid, sStall, sStop;
  logic [15:0] sData;

  always #5 clk = ~clk;

  stage_flow_ctrl u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .commitStall(commitStall), .commitSquash(commitSquash), .robSquash(robSquash),
    .queueFull(queueFull), .stallUp(stallUp), .outValid(outValid),
    .outData(outData), .status(status), .stopSquash(stopSquash)
  );

  task automatic check(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] d, input logic cs,
                      input logic sq, input logic rb, input logic qf);
    inValid = v; inData = d; commitStall = cs; commitSquash = sq; robSquash = rb; queueFull = qf;
    #2;
    sValid = outValid; sData = outData; sStall = stallUp; sStop = stopSquash;
    @(posedge clk); #1;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 status", status, 0);
    check("R1 stallUp", stallUp, 0);
    check("R1 outValid", outValid, 0);
    rstN = 1'b1;

    step(0, 0, 0, 0, 0, 0);
    check("R2 idle no bundle", sValid, 0);
    check("R2 idle kept", status, 0);
    for (int i = 0; i < 8; i++) begin
      step(1, 16'h00A0 + 16'(i), 0, 0, 0, 0);
      check("R2 pass valid", sValid, 1);
      check("R2 pass data", sData, 16'h00A0 + i);
      check("R2 running", status, 1);
    end

    // R3 / R5 / R6 / R7 / R11: sweep parked count 1..4
    for (int n = 1; n <= 4; n++) begin
      int base = 16'h100 * n;
      step(1, 16'(base), 1, 0, 0, 0);
      check("R3 no output on stall", sValid, 0);
      check("R3 blocked", status, 2);
      for (int k = 1; k < n; k++) begin
        step(1, 16'(base + k), 1, 0, 0, 0);
        check("R5 stall high", sStall, 1);
        check("R5 still blocked", status, 2);
      end
      step(0, 0, 0, 0, 0, 1);
      check("R6 full keeps block", status, 2);
      check("R5 stall high", sStall, 1);
      step(0, 0, 1, 0, 0, 0);
      check("R6 stall keeps block", status, 2);
      step(0, 0, 0, 0, 0, 0);
      check("R6 to unblocking", status, 4);
      for (int k = 0; k < n; k++) begin
        step(0, 0, 0, 0, 0, 0);
        check("R7 replay valid", sValid, 1);
        check(n == 4 ? "R11 full replay data" : "R7 replay data", sData, base + k);
        check("R7 stall while parked", sStall, 1);
      end
      check("R7 back to running", status, 1);
      step(0, 0, 0, 0, 0, 0);
      check("R7 nothing extra", sValid, 0);
      check("R7 stall released", sStall, 0);
    end

    // R10: stall beats flush
    step(1, 16'h0777, 1, 1, 0, 0);
    check("R10 stall wins", status, 2);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    check("R10 replay", sData, 16'h0777);
    check("R10 running", status, 1);

    // R4: full queue parks bundle
    step(1, 16'h0444, 0, 0, 0, 1);
    check("R4 not output", sValid, 0);
    check("R4 blocked", status, 2);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    check("R4 replay valid", sValid, 1);
    check("R4 replay data", sData, 16'h0444);
    check("R4 running", status, 1);

    // R8 / R9: flush while blocked, rollback flag alone holds
    step(1, 16'h0888, 1, 0, 0, 0);
    step(1, 16'h0889, 1, 0, 0, 0);
    step(0, 0, 1, 1, 0, 0);
    check("R8 to squashing", status, 3);
    step(1, 16'h0999, 0, 0, 1, 0);
    check("R9 held by rollback", status, 3);
    check("R9 no output", sValid, 0);
    check("R9 no early pulse", sStop, 0);
    step(0, 0, 0, 0, 0, 0);
    check("R9 stop pulse", sStop, 1);
    check("R9 running", status, 1);
    step(0, 0, 0, 0, 0, 0);
    check("R9 pulse one cycle", sStop, 0);
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    check("R8 unblocking", status, 4);
    step(0, 0, 0, 0, 0, 0);
    check("R8 no stale replay", sValid, 0);
    check("R8 running", status, 1);

    // R10: flush without stall from Running
    step(1, 16'h0555, 0, 1, 0, 0);
    check("R10 flush no output", sValid, 0);
    check("R10 squashing", status, 3);
    step(0, 0, 0, 0, 0, 0);
    check("R9 pulse after flush", sStop, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule